// File: doc/BRIEF.md
# Broadcast Invalidate Coherence Fabric

This block keeps a small group of private caches coherent over one shared broadcast bus. Each cache holds one data word for every line of a small address space, and every line in every cache is tracked as invalid, shared or dirty. A processor port per cache accepts read and write requests. Reads of a valid copy and writes to a dirty copy finish locally. Any other access needs a bus transaction: a fill read, an exclusive fill for a write, or an invalidate that upgrades a shared copy.

All transactions travel on one bus that every cache snoops. A round-robin arbiter admits at most one cache per cycle. A granted transaction completes in that same cycle: the requester's line is updated, every other cache applies the snoop action, and a dirty holder supplies its word and writes it back to the backing store. A processor whose request needs the bus waits, with its request held, until its cache is granted.

Top module: `snoop_coherence_fabric`

## Requirements
- R1: After a synchronous reset every line of every cache is invalid (state code 0), every `done` bit is low and the bus is idle (`bus_valid` low). The backing word for line l starts at (l*37+5) modulo 2^DW.
- R2: A read of an invalid line issues a fill read (bus command code 1). In the granted cycle the line becomes shared (code 1), and `rdata` takes the word of the dirty holder if one exists, otherwise the backing word.
- R3: A read of a shared or dirty line completes without a bus transaction. `done` rises the cycle after the request is presented, and the stored word is placed on `rdata`.
- R4: A write to a shared line issues an invalidate (code 3). The writer's line becomes dirty (code 2) with the new word, and every other cache's copy of that line becomes invalid.
- R5: A write to an invalid line issues an exclusive fill (code 2). The writer's line becomes dirty with the new word, and every other copy becomes invalid.
- R6: Reads and writes to a dirty line complete locally with no bus transaction.
- R7: When another cache's fill read finds this cache holding the line dirty, this cache supplies its word, the word is written back to the backing store, and this cache's copy drops to shared.
- R8: At most one cache owns the bus per cycle. Priority rotates, starting with the cache after the last winner (cache 0 first after reset). A requester waits at most NCACHE-1 cycles.
- R9: A locally completable request waits one cycle when another cache's transaction for the same line holds the bus in that cycle. It is then re-evaluated against the updated state.
- R10: Whenever a line is dirty in some cache, no other cache holds a valid copy of that line.
- R11: `done` is a single-cycle pulse per completed request. A request is accepted only while that cache's `done` is low, so the processor may present its next request together with the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCACHE | Request present, one bit per cache, held until done |
| req_write | input | NCACHE | 1 = write, 0 = read, per cache |
| req_line | input | NCACHE*LW | Line index per cache |
| req_wdata | input | NCACHE*DW | Write word per cache |
| done | output | NCACHE | Completion pulse per cache |
| rdata | output | NCACHE*DW | Last read word per cache |
| line_state | output | NCACHE*NLINE*2 | State of line l in cache c at bits [(c*NLINE+l)*2 +: 2]; 0 invalid, 1 shared, 2 dirty |
| bus_valid | output | 1 | A transaction occupies the bus this cycle |
| bus_owner | output | IW | Cache granted the bus |
| bus_cmd | output | 2 | 0 idle, 1 fill read, 2 exclusive fill, 3 invalidate |

## Verification
A wrong line state shows at the ports in the very next cycle as a mismatch in `line_state`. It also changes the next request's bus command on `bus_cmd`, or turns a bus access into a local completion and so moves the `done` pulse by one or more cycles. A lost write-back or a wrong fill source shows as a wrong `rdata` on the next read of that line by any cache. An arbitration fault shows as an unexpected `bus_owner` in the cycle of the grant. The bench predicts every one of these signals each cycle and compares them.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_DRT = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_INV  = 2'd3
    } bus_cmd_e;

    // Bus command a request needs, given the current copy state; idle = local
    function automatic bus_cmd_e pick_cmd(input logic is_wr, input line_st_e st);
        if (!is_wr)
            return (st == LS_INV) ? BC_RD : BC_IDLE;
        else if (st == LS_DRT)
            return BC_IDLE;
        else if (st == LS_SHR)
            return BC_INV;
        else
            return BC_RDX;
    endfunction

    function automatic int seed_word(input int idx);
        return idx * 37 + 5;
    endfunction

endpackage

// File: rtl/snoop_rr_arbiter.sv
`timescale 1ns/1ps
module snoop_rr_arbiter #(
    parameter int NREQ = 4,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant,
    output logic            gnt_valid,
    output logic [IW-1:0]   gnt_idx
);
    localparam int CW = IW + 2;

    logic [IW-1:0] last_q;

    always_comb begin
        logic [IW-1:0] ci;
        grant     = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= NREQ; k++) begin
            ci = IW'((int'(last_q) + k) % NREQ);
            if (!gnt_valid && req[ci]) begin
                gnt_valid = 1'b1;
                gnt_idx   = ci;
                grant[ci] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IW'(NREQ - 1);
        else if (gnt_valid)
            last_q <= gnt_idx;
    end

    // Waiting-time counters for the fairness check
    logic [CW-1:0] wait_q [NREQ];

    generate
        for (genvar g = 0; g < NREQ; g++) begin : g_wait
            always_ff @(posedge clk) begin
                if (rst || !req[g] || grant[g])
                    wait_q[g] <= '0;
                else
                    wait_q[g] <= wait_q[g] + 1'b1;
            end

            AST_RR_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
                (req[g] && !grant[g]) |-> (wait_q[g] < CW'(NREQ - 1))); // R8
        end
    endgenerate

endmodule

// File: rtl/snoop_backing_mem.sv
`timescale 1ns/1ps
module snoop_backing_mem import snoop_pkg::*; #(
    parameter int NLINE = 4,
    parameter int DW    = 8,
    localparam int LW   = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_line,
    input  logic [DW-1:0] wr_data,
    input  logic [LW-1:0] rd_line,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word_q [NLINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLINE; l++)
                word_q[l] <= DW'(seed_word(l));
        end else if (wr_en) begin
            word_q[wr_line] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_line];

endmodule

// File: rtl/snoop_line_ctrl.sv
`timescale 1ns/1ps
module snoop_line_ctrl import snoop_pkg::*; #(
    parameter int NCACHE = 4,
    parameter int NLINE  = 4,
    parameter int DW     = 8,
    parameter int MY_ID  = 0,
    localparam int IW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int LW    = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic               clk,
    input  logic               rst,
    // processor side
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LW-1:0]      req_line,
    input  logic [DW-1:0]      req_wdata,
    output logic               done,
    output logic [DW-1:0]      rdata,
    // bus request side
    output logic               bus_req,
    output bus_cmd_e           bus_want,
    input  logic               grant,
    // snooped broadcast
    input  logic               bus_vld,
    input  bus_cmd_e           bus_cmd,
    input  logic [IW-1:0]      bus_own,
    input  logic [LW-1:0]      bus_line,
    input  logic [DW-1:0]      bus_fill,
    // snoop response
    output logic               holds_dirty,
    output logic [DW-1:0]      line_word,
    output logic [NLINE*2-1:0] state_flat
);
    localparam logic [IW-1:0] ME = IW'(MY_ID);

    line_st_e      st_q   [NLINE];
    logic [DW-1:0] data_q [NLINE];

    logic active, snoop_hit, clash, local_ok;

    always_comb begin
        active    = req_valid && !done;
        bus_want  = pick_cmd(req_write, st_q[req_line]);
        bus_req   = active && (bus_want != BC_IDLE);
        snoop_hit = bus_vld && (bus_own != ME);
        clash     = snoop_hit && (bus_line == req_line);
        local_ok  = active && (bus_want == BC_IDLE) && !clash;
    end

    assign holds_dirty = (st_q[bus_line] == LS_DRT);
    assign line_word   = data_q[bus_line];

    generate
        for (genvar l = 0; l < NLINE; l++) begin : g_flat
            assign state_flat[2*l +: 2] = st_q[l];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLINE; l++) begin
                st_q[l]   <= LS_INV;
                data_q[l] <= '0;
            end
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            // snoop action for another cache's transaction
            if (snoop_hit) begin
                case (bus_cmd)
                    BC_RD:         if (st_q[bus_line] == LS_DRT) st_q[bus_line] <= LS_SHR;
                    BC_RDX, BC_INV: st_q[bus_line] <= LS_INV;
                    default: ;
                endcase
            end
            // own bus transaction completes in the granted cycle
            if (grant) begin
                done <= 1'b1;
                if (bus_cmd == BC_RD) begin
                    st_q[req_line]   <= LS_SHR;
                    data_q[req_line] <= bus_fill;
                    rdata            <= bus_fill;
                end else begin
                    st_q[req_line]   <= LS_DRT;
                    data_q[req_line] <= req_wdata;
                end
            end else if (local_ok) begin
                done <= 1'b1;
                if (req_write)
                    data_q[req_line] <= req_wdata;
                else
                    rdata <= data_q[req_line];
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_WR_GRANT_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (grant && req_write) |=> (st_q[$past(req_line)] == LS_DRT)); // R5

    AST_RD_GRANT_SHARED: assert property (@(posedge clk) disable iff (rst)
        (grant && !req_write) |=> (st_q[$past(req_line)] == LS_SHR)); // R2

endmodule

// File: rtl/snoop_coherence_fabric.sv
`timescale 1ns/1ps
module snoop_coherence_fabric import snoop_pkg::*; #(
    parameter int NCACHE = 4,
    parameter int NLINE  = 4,
    parameter int DW     = 8,
    localparam int IW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
    localparam int LW    = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCACHE-1:0]         req_valid,
    input  logic [NCACHE-1:0]         req_write,
    input  logic [NCACHE*LW-1:0]      req_line,
    input  logic [NCACHE*DW-1:0]      req_wdata,
    output logic [NCACHE-1:0]         done,
    output logic [NCACHE*DW-1:0]      rdata,
    output logic [NCACHE*NLINE*2-1:0] line_state,
    output logic                      bus_valid,
    output logic [IW-1:0]             bus_owner,
    output logic [1:0]                bus_cmd
);
    logic [NCACHE-1:0] c_req, c_grant, c_dirty;
    bus_cmd_e          c_want [NCACHE];
    logic [DW-1:0]     c_word [NCACHE];

    logic          g_vld;
    logic [IW-1:0] g_idx;
    bus_cmd_e      b_cmd;
    logic [LW-1:0] b_line;
    logic [DW-1:0] b_fill, mem_word, dirty_word;
    logic          any_dirty;

    snoop_rr_arbiter #(.NREQ(NCACHE)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (c_req),
        .grant     (c_grant),
        .gnt_valid (g_vld),
        .gnt_idx   (g_idx)
    );

    // broadcast contents driven by the granted cache
    always_comb begin
        b_cmd      = BC_IDLE;
        b_line     = '0;
        any_dirty  = 1'b0;
        dirty_word = '0;
        for (int c = 0; c < NCACHE; c++) begin
            if (c_grant[c]) begin
                b_cmd  = c_want[c];
                b_line = req_line[c*LW +: LW];
            end
        end
        for (int c = 0; c < NCACHE; c++) begin
            if (g_vld && c_dirty[c]) begin
                any_dirty  = 1'b1;
                dirty_word = dirty_word | c_word[c];
            end
        end
        b_fill = any_dirty ? dirty_word : mem_word;
    end

    snoop_backing_mem #(.NLINE(NLINE), .DW(DW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (any_dirty),
        .wr_line (b_line),
        .wr_data (dirty_word),
        .rd_line (b_line),
        .rd_data (mem_word)
    );

    generate
        for (genvar g = 0; g < NCACHE; g++) begin : g_cache
            snoop_line_ctrl #(
                .NCACHE (NCACHE),
                .NLINE  (NLINE),
                .DW     (DW),
                .MY_ID  (g)
            ) u_ctrl (
                .clk         (clk),
                .rst         (rst),
                .req_valid   (req_valid[g]),
                .req_write   (req_write[g]),
                .req_line    (req_line[g*LW +: LW]),
                .req_wdata   (req_wdata[g*DW +: DW]),
                .done        (done[g]),
                .rdata       (rdata[g*DW +: DW]),
                .bus_req     (c_req[g]),
                .bus_want    (c_want[g]),
                .grant       (c_grant[g]),
                .bus_vld     (g_vld),
                .bus_cmd     (b_cmd),
                .bus_own     (g_idx),
                .bus_line    (b_line),
                .bus_fill    (b_fill),
                .holds_dirty (c_dirty[g]),
                .line_word   (c_word[g]),
                .state_flat  (line_state[g*NLINE*2 +: NLINE*2])
            );
        end
    endgenerate

    assign bus_valid = g_vld;
    assign bus_owner = g_idx;
    assign bus_cmd   = b_cmd;

    // coherence invariant, one check per line
    generate
        for (genvar l = 0; l < NLINE; l++) begin : g_inv
            int n_valid, n_dirty;
            always_comb begin
                n_valid = 0;
                n_dirty = 0;
                for (int c = 0; c < NCACHE; c++) begin
                    if (line_state[(c*NLINE+l)*2 +: 2] != 2'd0) n_valid++;
                    if (line_state[(c*NLINE+l)*2 +: 2] == 2'd2) n_dirty++;
                end
            end
            AST_SOLE_DIRTY_COPY: assert property (@(posedge clk) disable iff (rst)
                (n_dirty != 0) |-> (n_valid == 1)); // R10
        end
    endgenerate

    AST_BUS_OWNER_ASKED: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (c_req[bus_owner] && $onehot0(c_grant))); // R8

endmodule

// File: tb/snoop_coherence_fabric_tb.sv
`timescale 1ns/1ps
module snoop_coherence_fabric_tb_top;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int DW = 8;
    localparam int LW = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NC-1:0]      req_valid = '0;
    logic [NC-1:0]      req_write = '0;
    logic [NC*LW-1:0]   req_line  = '0;
    logic [NC*DW-1:0]   req_wdata = '0;
    logic [NC-1:0]      done;
    logic [NC*DW-1:0]   rdata;
    logic [NC*NL*2-1:0] line_state;
    logic               bus_valid;
    logic [IW-1:0]      bus_owner;
    logic [1:0]         bus_cmd;

    snoop_coherence_fabric #(.NCACHE(NC), .NLINE(NL), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .line_state(line_state), .bus_valid(bus_valid), .bus_owner(bus_owner),
        .bus_cmd(bus_cmd)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int bus_cnt = 0;
    int owner_log [$];

    // reference model
    int ms [NC][NL];
    int md [NC][NL];
    int mm [NL];
    int mdone [NC];
    int mrdata [NC];
    int rr_last;
    int mgv, mown, mcmd, mline;
    int ops [NC][$];

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int cmd_of(input int c);
        int st;
        st = ms[c][req_line[c*LW +: LW]];
        if (!req_write[c]) return (st == 0) ? 1 : 0;
        if (st == 2) return 0;
        if (st == 1) return 3;
        return 2;
    endfunction

    task automatic model_comb();
        mgv = 0; mown = 0; mcmd = 0; mline = 0;
        for (int k = 1; k <= NC; k++) begin
            int c;
            c = (rr_last + k) % NC;
            if (mgv == 0 && req_valid[c] && mdone[c] == 0 && cmd_of(c) != 0) begin
                mgv = 1; mown = c; mcmd = cmd_of(c);
                mline = req_line[c*LW +: LW];
            end
        end
    endtask

    task automatic model_edge();
        int tms [NC][NL];
        int tmd [NC][NL];
        int tdone [NC];
        int fill, dd;
        bit anyd;
        tms = ms; tmd = md;
        anyd = 0; dd = 0;
        for (int c = 0; c < NC; c++) tdone[c] = 0;
        if (mgv != 0) begin
            for (int c = 0; c < NC; c++)
                if (ms[c][mline] == 2) begin anyd = 1; dd = md[c][mline]; end
            fill = anyd ? dd : mm[mline];
            if (anyd) mm[mline] = dd;
            for (int c = 0; c < NC; c++) begin
                if (c != mown) begin
                    if (mcmd == 1 && ms[c][mline] == 2) tms[c][mline] = 1;
                    else if (mcmd >= 2) tms[c][mline] = 0;
                end
            end
            tdone[mown] = 1;
            if (mcmd == 1) begin
                tms[mown][mline] = 1; tmd[mown][mline] = fill; mrdata[mown] = fill;
            end else begin
                tms[mown][mline] = 2; tmd[mown][mline] = int'(req_wdata[mown*DW +: DW]);
            end
        end
        for (int c = 0; c < NC; c++) begin
            int l;
            l = req_line[c*LW +: LW];
            if (req_valid[c] && mdone[c] == 0 && cmd_of(c) == 0 &&
                !(mgv != 0 && mline == l && mown != c)) begin
                tdone[c] = 1;
                if (req_write[c]) tmd[c][l] = int'(req_wdata[c*DW +: DW]);
                else mrdata[c] = md[c][l];
            end
        end
        if (mgv != 0) rr_last = mown;
        ms = tms; md = tmd; mdone = tdone;
    endtask

    task automatic load(input int c);
        int op;
        op = ops[c].pop_front();
        req_valid[c] = 1'b1;
        req_write[c] = op[16];
        req_line[c*LW +: LW] = op[9:8];
        req_wdata[c*DW +: DW] = op[7:0];
    endtask

    task automatic push(input int c, input int w, input int l, input int d);
        ops[c].push_back((w << 16) | (l << 8) | (d & 255));
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog R11 act=%0d exp=%0d", cyc, 150000);
            finish_up();
        end
        for (int c = 0; c < NC; c++) begin
            chk(done[c] == 1'(mdone[c]), "R11 done pulse", int'(done[c]), mdone[c]);
            chk(int'(rdata[c*DW +: DW]) == mrdata[c], "R2 rdata", int'(rdata[c*DW +: DW]), mrdata[c]);
            for (int l = 0; l < NL; l++)
                chk(int'(line_state[(c*NL+l)*2 +: 2]) == ms[c][l], "R7 line state",
                    int'(line_state[(c*NL+l)*2 +: 2]), ms[c][l]);
        end
        for (int l = 0; l < NL; l++) begin
            int nv, nd;
            nv = 0; nd = 0;
            for (int c = 0; c < NC; c++) begin
                if (line_state[(c*NL+l)*2 +: 2] != 0) nv++;
                if (line_state[(c*NL+l)*2 +: 2] == 2) nd++;
            end
            chk(nd == 0 || nv == 1, "R10 sole dirty copy", nv, 1);
        end
        for (int c = 0; c < NC; c++) begin
            if (req_valid[c] && mdone[c] != 0) begin
                if (ops[c].size() > 0) load(c); else req_valid[c] = 1'b0;
            end else if (!req_valid[c] && ops[c].size() > 0) begin
                load(c);
            end
        end
        #1;
        model_comb();
        chk(bus_valid == 1'(mgv), "R8 bus valid", int'(bus_valid), mgv);
        if (mgv != 0) begin
            chk(int'(bus_owner) == mown, "R8 bus owner", int'(bus_owner), mown);
            chk(int'(bus_cmd) == mcmd, (mcmd == 1) ? "R2 fill cmd" : (mcmd == 2) ? "R5 excl cmd" : "R4 inv cmd",
                int'(bus_cmd), mcmd);
            bus_cnt++;
            owner_log.push_back(int'(bus_owner));
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic run_idle();
        int n;
        bit busy;
        bus_cnt = 0;
        owner_log.delete();
        n = 0;
        busy = 1;
        while (busy) begin
            step();
            n++;
            busy = 0;
            for (int c = 0; c < NC; c++)
                if (ops[c].size() > 0 || req_valid[c] || mdone[c] != 0) busy = 1;
            if (n > 5000) begin
                errors++; checks++;
                $display("FAIL hang R8 act=%0d exp=%0d", n, 5000);
                finish_up();
            end
        end
        step();
    endtask

    function automatic int st_of(input int c, input int l);
        return int'(line_state[(c*NL+l)*2 +: 2]);
    endfunction

    function automatic int rd_of(input int c);
        return int'(rdata[c*DW +: DW]);
    endfunction

    initial begin
        int lfsr;
        for (int c = 0; c < NC; c++) begin
            mdone[c] = 0; mrdata[c] = 0;
            for (int l = 0; l < NL; l++) begin ms[c][l] = 0; md[c][l] = 0; end
        end
        for (int l = 0; l < NL; l++) mm[l] = (l * 37 + 5) & 255;
        rr_last = NC - 1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        chk(line_state == '0, "R1 states invalid", int'(line_state), 0);
        chk(done == '0, "R1 done low", int'(done), 0);
        chk(bus_valid == 1'b0, "R1 bus idle", int'(bus_valid), 0);

        // R2 fill read from backing store
        push(0, 0, 1, 0); run_idle();
        chk(rd_of(0) == 8'h2A, "R2 fill word", rd_of(0), 8'h2A);
        chk(st_of(0, 1) == 1, "R2 shared after fill", st_of(0, 1), 1);
        chk(bus_cnt == 1, "R2 one transaction", bus_cnt, 1);

        // R3 shared read stays local
        push(0, 0, 1, 0); run_idle();
        chk(bus_cnt == 0, "R3 no bus on shared read", bus_cnt, 0);

        // R4 upgrade by invalidate
        push(1, 0, 1, 0); push(1, 1, 1, 8'hA5); run_idle();
        chk(st_of(0, 1) == 0, "R4 other copy invalid", st_of(0, 1), 0);
        chk(st_of(1, 1) == 2, "R4 writer dirty", st_of(1, 1), 2);

        // R6 dirty accesses stay local
        push(1, 1, 1, 8'h3C); push(1, 0, 1, 0); run_idle();
        chk(bus_cnt == 0, "R6 no bus on dirty access", bus_cnt, 0);
        chk(rd_of(1) == 8'h3C, "R6 dirty read word", rd_of(1), 8'h3C);

        // R7 dirty holder supplies data and writes back
        push(2, 0, 1, 0); run_idle();
        chk(rd_of(2) == 8'h3C, "R7 supplied word", rd_of(2), 8'h3C);
        chk(st_of(1, 1) == 1, "R7 holder drops to shared", st_of(1, 1), 1);
        push(3, 0, 1, 0); run_idle();
        chk(rd_of(3) == 8'h3C, "R7 written back word", rd_of(3), 8'h3C);

        // R5 write miss
        push(0, 1, 2, 8'h77); run_idle();
        chk(st_of(0, 2) == 2, "R5 writer dirty", st_of(0, 2), 2);
        chk(bus_cnt == 1, "R5 one transaction", bus_cnt, 1);

        // R8 rotating priority: last winner 0, so order 1,2,3,0
        for (int c = 0; c < NC; c++) push(c, 1, 3, 8'h10 + c);
        run_idle();
        chk(owner_log.size() == 4, "R8 four grants", owner_log.size(), 4);
        for (int k = 0; k < 4 && k < owner_log.size(); k++)
            chk(owner_log[k] == (k + 1) % 4, "R8 grant order", owner_log[k], (k + 1) % 4);
        chk(st_of(0, 3) == 2, "R8 last writer dirty", st_of(0, 3), 2);

        // R9 local hit waits behind a same-line bus transaction
        push(0, 1, 3, 8'h99); push(1, 0, 3, 0); run_idle();
        chk(rd_of(1) == 8'h10, "R9 reader sees older word", rd_of(1), 8'h10);
        chk(st_of(0, 3) == 2, "R9 writer dirty again", st_of(0, 3), 2);
        chk(st_of(1, 3) == 0, "R9 reader invalidated", st_of(1, 3), 0);
        chk(bus_cnt == 2, "R9 two transactions", bus_cnt, 2);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
            push(lfsr & 3, (lfsr >> 2) & 1, (lfsr >> 3) & 3, lfsr >> 5);
        end
        run_idle();

        finish_up();
    end

endmodule